// File: doc/BRIEF.md
# Transmit Cell Buffer with Short-Cell Completion

This block sits in the transmit path between a bus-side producer and a line-side consumer, and both sides share one clock. The producer hands over bytes one at a time and flags the final byte of each cell. The consumer drains the buffer one byte per accepted pop. Every cell that leaves the buffer is exactly 53 bytes long. If the producer closes a cell early, the write side fills the rest of that cell with zero bytes before the cell can be read. The far end therefore never sees a short cell and keeps its cell alignment.

The buffer counts its storage in whole cells. Software sets how many cells may be held at once, from one to nine. The consumer sees a cell-available flag once at least one finished cell is stored. The producer sees a full flag and a ready signal that refuses the start of a new cell when no cell slot is free.

Top module: `cell_tx_buffer`

## Requirements
- R1: After reset, `wr_ready` is 1, `cell_avail` is 0 and `full` is 0.
- R2: A cell of exactly 53 bytes leaves the buffer unchanged. An end marker on its 53rd byte adds no pad bytes. `rd_last` is 1 on the 53rd byte of each cell read and 0 on all other bytes.
- R3: A cell closed by the end marker after k bytes, with k from 1 to 52, is read as those k bytes followed by 53-k bytes of value 0x00.
- R4: Once the marker of such a short cell is accepted, `wr_ready` stays 0 for exactly 53-k clock cycles, one pad byte per cycle, and then returns to 1 when a cell slot is free.
- R5: `cell_avail` is 1 only while at least one completed cell is stored. It rises in the cycle after the 53rd byte of a cell (data or pad) is written. A pop while `cell_avail` is 0 has no effect.
- R6: A 54th byte written without an earlier end marker becomes the first byte of a new cell.
- R7: The usable depth is `cfg_depth` when that value is 1 to 9. A value of 0 or above 9 gives a depth of 9.
- R8: `full` is 1 whenever the number of stored cells, counting a partly written cell, reaches the usable depth. While `full` is 1, the first byte of a new cell is refused (`wr_ready` is 0). The remaining bytes of a cell already being written are still accepted.
- R9: Cells and bytes leave in the order they were written, including when the cell slots wrap around.
- R10: A cell completed on the write side in the same cycle that a cell finishes reading keeps the stored cell count correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 4 | Requested depth in cells (clamped as in R7) |
| wr_valid | input | 1 | Producer offers a byte |
| wr_data | input | 8 | Byte offered |
| wr_last | input | 1 | Offered byte closes the current cell |
| wr_ready | output | 1 | Byte is taken at the next clock edge when `wr_valid` is 1 |
| rd_pop | input | 1 | Consumer takes the byte on `rd_data` |
| rd_data | output | 8 | Byte at the head of the buffer |
| rd_last | output | 1 | Head byte is the 53rd of its cell |
| cell_avail | output | 1 | At least one completed cell is stored |
| full | output | 1 | Stored cells have reached the usable depth |

## Verification
The main function is tried with several kinds of cell. Cells with a marker on byte 53 show that exact-length cells pass without padding. Short cells of 1 and 10 bytes confirm both the count of zero bytes and the length of the stall. A 60-byte run without an early marker separates "start a new cell" from "extend the current one". Two depth patterns are also used. With the reader stalled, the buffer is filled at depths 3, 1 and the clamped 9; this shows when `full` rises and that a new cell is refused while a partly written cell is still accepted. A stream of mixed lengths, read while it is being written, exercises slot wrap-around and completions on both sides in the same cycle against the scoreboard's byte order.

// File: rtl/cell_tx_buffer_pkg.sv
package cell_tx_buffer_pkg;

  // value written into the unused tail of a short cell
  localparam int PAD_BYTE = 0;

  typedef enum logic {
    WS_DATA = 1'b0,
    WS_PAD  = 1'b1
  } wr_state_e;

  // usable depth: out-of-range requests fall back to the largest depth
  function automatic int clamp_depth(input int req, input int max_cells);
    if (req == 0 || req > max_cells) return max_cells;
    return req;
  endfunction

  // flat byte address of (slot, index) in cell-slot storage
  function automatic int cell_addr(input int slot, input int idx, input int cell_bytes);
    return slot * cell_bytes + idx;
  endfunction

  // circular slot advance
  function automatic int next_slot(input int slot, input int max_cells);
    return (slot == max_cells - 1) ? 0 : slot + 1;
  endfunction

endpackage

// File: rtl/cbuf_store.sv
module cbuf_store #(
  parameter int DATA_W  = 8,
  parameter int ENTRIES = 477,
  parameter int ADDR_W  = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/cbuf_wr_ctrl.sv
module cbuf_wr_ctrl
  import cell_tx_buffer_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int MAX_CELLS  = 9,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 6,
  parameter int SLOT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  input  logic              room,
  output logic              wr_ready,
  output logic              we,
  output logic [DATA_W-1:0] w_byte,
  output logic [SLOT_W-1:0] w_slot,
  output logic [IDX_W-1:0]  w_idx,
  output logic              cell_done,
  output logic              pad_active,
  output logic              cell_open
);

  wr_state_e   st_q;
  logic        wr_fire;
  logic        at_end;

  assign pad_active = (st_q == WS_PAD);
  assign wr_ready   = !pad_active && ((w_idx != '0) || room);
  assign wr_fire    = wr_valid && wr_ready;
  assign we         = wr_fire || pad_active;
  assign w_byte     = pad_active ? DATA_W'(PAD_BYTE) : wr_data;
  assign at_end     = (w_idx == IDX_W'(CELL_BYTES - 1));
  assign cell_done  = we && at_end;
  assign cell_open  = (w_idx != '0) || pad_active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WS_DATA;
      w_idx  <= '0;
      w_slot <= '0;
    end else if (we) begin
      if (at_end) begin
        w_idx  <= '0;
        w_slot <= SLOT_W'(next_slot(32'(w_slot), MAX_CELLS));
        st_q   <= WS_DATA;
      end else begin
        w_idx <= w_idx + IDX_W'(1);
        if (wr_fire && wr_last) st_q <= WS_PAD;
      end
    end
  end

endmodule

// File: rtl/cbuf_rd_ctrl.sv
module cbuf_rd_ctrl
  import cell_tx_buffer_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int MAX_CELLS  = 9,
  parameter int IDX_W      = 6,
  parameter int SLOT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_pop,
  input  logic              cell_avail,
  output logic [SLOT_W-1:0] r_slot,
  output logic [IDX_W-1:0]  r_idx,
  output logic              rd_last,
  output logic              cell_read
);

  logic rd_fire;

  assign rd_fire   = rd_pop && cell_avail;
  assign rd_last   = (r_idx == IDX_W'(CELL_BYTES - 1));
  assign cell_read = rd_fire && rd_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_idx  <= '0;
      r_slot <= '0;
    end else if (rd_fire) begin
      if (rd_last) begin
        r_idx  <= '0;
        r_slot <= SLOT_W'(next_slot(32'(r_slot), MAX_CELLS));
      end else begin
        r_idx <= r_idx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/cbuf_occupancy.sv
module cbuf_occupancy
  import cell_tx_buffer_pkg::*;
#(
  parameter int MAX_CELLS = 9,
  parameter int CNT_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_depth,
  input  logic             cell_done,
  input  logic             cell_read,
  input  logic             cell_open,
  output logic [CNT_W-1:0] done_cnt,
  output logic [CNT_W-1:0] eff_depth,
  output logic [CNT_W:0]   used_cnt,
  output logic             cell_avail,
  output logic             full,
  output logic             room
);

  assign eff_depth  = CNT_W'(clamp_depth(32'(cfg_depth), MAX_CELLS));
  assign used_cnt   = {1'b0, done_cnt} + (CNT_W + 1)'(cell_open);
  assign full       = used_cnt >= {1'b0, eff_depth};
  assign room       = !full;
  assign cell_avail = (done_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_cnt <= '0;
    end else begin
      unique case ({cell_done, cell_read})
        2'b10:   done_cnt <= done_cnt + CNT_W'(1);
        2'b01:   done_cnt <= done_cnt - CNT_W'(1);
        default: done_cnt <= done_cnt;
      endcase
    end
  end

endmodule

// File: rtl/cell_tx_buffer.sv
module cell_tx_buffer
  import cell_tx_buffer_pkg::*;
#(
  parameter int  CELL_BYTES = 53,
  parameter int  MAX_CELLS  = 9,
  parameter int  DATA_W     = 8,
  localparam int CNT_W      = $clog2(MAX_CELLS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_depth,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_ready,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              cell_avail,
  output logic              full
);

  localparam int IDX_W   = $clog2(CELL_BYTES);
  localparam int SLOT_W  = (MAX_CELLS > 1) ? $clog2(MAX_CELLS) : 1;
  localparam int ENTRIES = MAX_CELLS * CELL_BYTES;
  localparam int ADDR_W  = $clog2(ENTRIES);

  // internal events, also observed by the bound checker
  logic              we;
  logic [DATA_W-1:0] w_byte;
  logic [SLOT_W-1:0] w_slot;
  logic [IDX_W-1:0]  w_idx;
  logic              cell_done;
  logic              pad_active;
  logic              cell_open;
  logic [SLOT_W-1:0] r_slot;
  logic [IDX_W-1:0]  r_idx;
  logic              cell_read;
  logic [CNT_W-1:0]  done_cnt;
  logic [CNT_W-1:0]  eff_depth;
  logic [CNT_W:0]    used_cnt;
  logic              room;
  logic [ADDR_W-1:0] waddr;
  logic [ADDR_W-1:0] raddr;

  assign waddr = ADDR_W'(cell_addr(32'(w_slot), 32'(w_idx), CELL_BYTES));
  assign raddr = ADDR_W'(cell_addr(32'(r_slot), 32'(r_idx), CELL_BYTES));

  cbuf_wr_ctrl #(
    .CELL_BYTES(CELL_BYTES), .MAX_CELLS(MAX_CELLS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_last(wr_last), .room(room), .wr_ready(wr_ready), .we(we),
    .w_byte(w_byte), .w_slot(w_slot), .w_idx(w_idx), .cell_done(cell_done),
    .pad_active(pad_active), .cell_open(cell_open)
  );

  cbuf_rd_ctrl #(
    .CELL_BYTES(CELL_BYTES), .MAX_CELLS(MAX_CELLS),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_pop(rd_pop), .cell_avail(cell_avail),
    .r_slot(r_slot), .r_idx(r_idx), .rd_last(rd_last), .cell_read(cell_read)
  );

  cbuf_occupancy #(
    .MAX_CELLS(MAX_CELLS), .CNT_W(CNT_W)
  ) u_occ (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cell_done(cell_done),
    .cell_read(cell_read), .cell_open(cell_open), .done_cnt(done_cnt),
    .eff_depth(eff_depth), .used_cnt(used_cnt), .cell_avail(cell_avail),
    .full(full), .room(room)
  );

  cbuf_store #(
    .DATA_W(DATA_W), .ENTRIES(ENTRIES), .ADDR_W(ADDR_W)
  ) u_mem (
    .clk(clk), .we(we), .waddr(waddr), .wdata(w_byte),
    .raddr(raddr), .rdata(rd_data)
  );

endmodule

// File: rtl/cell_tx_buffer_chk.sv
module cell_tx_buffer_chk #(
  parameter int MAX_CELLS = 9,
  parameter int DATA_W    = 8,
  parameter int CNT_W     = 4,
  parameter int IDX_W     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ready,
  input logic              rd_pop,
  input logic              rd_last,
  input logic              cell_avail,
  input logic              full,
  input logic              we,
  input logic [DATA_W-1:0] w_byte,
  input logic              cell_done,
  input logic              pad_active,
  input logic              cell_open,
  input logic [IDX_W-1:0]  r_idx,
  input logic [CNT_W-1:0]  eff_depth,
  input logic [CNT_W:0]    used_cnt
);

  AST_PAD_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    pad_active |-> !wr_ready); // R4

  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pad_active |-> (we && (w_byte == '0))); // R3

  AST_FULL_REFUSES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !cell_open) |-> !wr_ready); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    used_cnt <= (CNT_W + 1)'(MAX_CELLS)); // R8

  AST_AVAIL_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_avail) |-> $past(cell_done)); // R5

  AST_IDLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !cell_avail) |=> $stable(r_idx)); // R5

  AST_LAST_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && cell_avail && rd_last) |=> (r_idx == '0)); // R2

  AST_DEPTH_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_depth != '0) && (eff_depth <= CNT_W'(MAX_CELLS))); // R7

endmodule

bind cell_tx_buffer cell_tx_buffer_chk #(
  .MAX_CELLS(MAX_CELLS), .DATA_W(DATA_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_pop(rd_pop),
  .rd_last(rd_last), .cell_avail(cell_avail), .full(full), .we(we),
  .w_byte(w_byte), .cell_done(cell_done), .pad_active(pad_active),
  .cell_open(cell_open), .r_idx(r_idx), .eff_depth(eff_depth),
  .used_cnt(used_cnt)
);

// File: tb/cell_tx_buffer_tb.sv
module cell_tx_buffer_tb;

  localparam int CB = 53;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_depth = 4'd9;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic       wr_ready;
  logic       rd_pop = 1'b0;
  logic [7:0] rd_data;
  logic       rd_last;
  logic       cell_avail;
  logic       full;

  always #4 clk = ~clk;

  cell_tx_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_last(rd_last),
    .cell_avail(cell_avail), .full(full)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit rd_enable = 0;
  bit force_pop = 0;
  int wpos = 0;
  // {pad flag, expected last, byte}
  logic [9:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: pops whenever allowed and compares against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_enable && cell_avail) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "byte with empty scoreboard", int'(rd_data), -1);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check(rd_data == e[7:0], e[9] ? "R3" : "R9", "read byte", int'(rd_data), int'(e[7:0]));
        check(rd_last == e[8], "R2", "last flag", int'(rd_last), int'(e[8]));
      end
      rd_pop = 1'b1;
    end else begin
      rd_pop = force_pop;
    end
  end

  task automatic push_byte(input logic [7:0] d, input bit lst);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    wr_last  = lst;
    while (!wr_ready) @(negedge clk);
  endtask

  task automatic write_cell(input int n, input bit mark, input int seed);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed + i * 7);
      push_byte(d, mark && (i == n - 1));
      exp_q.push_back({1'b0, wpos == CB - 1, d});
      wpos = (wpos == CB - 1) ? 0 : wpos + 1;
    end
    if (mark) begin
      while (wpos != 0) begin
        exp_q.push_back({1'b1, wpos == CB - 1, 8'h00});
        wpos = (wpos == CB - 1) ? 0 : wpos + 1;
      end
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic count_stall(output int c);
    c = 0;
    while (!wr_ready && c < 200) begin
      c++;
      @(negedge clk);
    end
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    rd_enable = 1;
    while (exp_q.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    rd_enable = 0;
    @(negedge clk);
    check(cell_avail == 1'b0, "R5", "cell_avail after drain", int'(cell_avail), 0);
    check(exp_q.size() == 0, "R9", "scoreboard left", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int c;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(wr_ready == 1'b1, "R1", "wr_ready", int'(wr_ready), 1);
    check(cell_avail == 1'b0, "R1", "cell_avail", int'(cell_avail), 0);
    check(full == 1'b0, "R1", "full", int'(full), 0);

    // R2 / R5: exact-length cell, marker on byte 53, idle pops ignored
    write_cell(52, 0, 3);
    check(cell_avail == 1'b0, "R5", "partial cell visible", int'(cell_avail), 0);
    force_pop = 1;
    repeat (3) @(negedge clk);
    force_pop = 0;
    write_cell(1, 1, 91);
    check(cell_avail == 1'b1, "R5", "cell_avail after byte 53", int'(cell_avail), 1);
    check(wr_ready == 1'b1, "R2", "no pad stall on exact cell", int'(wr_ready), 1);
    drain();

    // R3 / R4: short cell of 10 bytes
    write_cell(10, 1, 17);
    count_stall(c);
    check(c == 43, "R4", "pad stall cycles k=10", c, 43);
    check(cell_avail == 1'b1, "R5", "cell_avail after padding", int'(cell_avail), 1);
    drain();

    // R3 / R4: short cell of 1 byte
    write_cell(1, 1, 200);
    count_stall(c);
    check(c == 52, "R4", "pad stall cycles k=1", c, 52);
    drain();

    // R6: 60 bytes, no early marker
    write_cell(60, 1, 33);
    count_stall(c);
    check(c == 46, "R6", "second cell padded from byte 8", c, 46);
    drain();

    // R8: depth 3, partly written cell counts
    cfg_depth = 4'd3;
    write_cell(53, 0, 5);
    write_cell(53, 0, 9);
    write_cell(5, 0, 77);
    check(full == 1'b1, "R8", "full with open third cell", int'(full), 1);
    check(wr_ready == 1'b1, "R8", "open cell still accepted", int'(wr_ready), 1);
    write_cell(1, 1, 111);
    repeat (50) @(negedge clk);
    check(full == 1'b1, "R8", "full at depth 3", int'(full), 1);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = 8'hAA; wr_last = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check(wr_ready == 1'b0, "R8", "new cell refused when full", int'(wr_ready), 0);
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    drain();

    // R7: depth 0 clamps to 9
    cfg_depth = 4'd0;
    for (int k = 0; k < 8; k++) write_cell(53, 0, 10 * k + 1);
    repeat (2) @(negedge clk);
    check(full == 1'b0, "R7", "8 cells at clamped depth", int'(full), 0);
    write_cell(53, 0, 99);
    @(negedge clk);
    check(full == 1'b1, "R7", "9 cells at clamped depth", int'(full), 1);
    check(wr_ready == 1'b0, "R7", "10th cell refused", int'(wr_ready), 0);
    cfg_depth = 4'd12;
    @(negedge clk);
    check(full == 1'b1, "R7", "depth 12 clamps to 9", int'(full), 1);
    cfg_depth = 4'd9;
    drain();

    // R7: depth 1
    cfg_depth = 4'd1;
    write_cell(53, 0, 44);
    @(negedge clk);
    check(full == 1'b1, "R7", "depth 1 full after one cell", int'(full), 1);
    check(wr_ready == 1'b0, "R7", "depth 1 refuses second", int'(wr_ready), 0);
    drain();

    // R9 / R10: mixed lengths streamed while reading, slots wrap
    cfg_depth = 4'd4;
    rd_enable = 1;
    for (int k = 0; k < 20; k++) begin
      int len;
      case (k % 5)
        0: len = 53;
        1: len = 17;
        2: len = 60;
        3: len = 1;
        default: len = 52;
      endcase
      write_cell(len, 1, 3 * k + 2);
    end
    drain();

    finish_run();
  end

endmodule